// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer with Wait States

This block turns one memory request at a time into a processor-side read or write bus cycle, stepping through a fixed list of clock states. A mode input picks the cycle length. The long cycle has four base states: T1, T2, T3 and T4. The short cycle has two base states: T1 and T2. Wait states go in after the state that carries the address. In the long cycle that is after T2, and in the short cycle after T1.

The number of waits comes from the memory's access time, given in tenths of a clock period. The block compares it with the access time the processor allows. That allowance is 15 tenths in the long mode and 23 tenths in the short mode. Whatever part of the memory time is left over is rounded up to whole clocks. Once those waits are used up, a low ready input holds the cycle back by one clock for each sample it is low.

A requester raises `req` with the address, data and direction. The request counts as taken when `addr_strobe` rises on the next clock. `ack` marks the end of the cycle. A new request can be taken in the last state of a running cycle, so two cycles can run back to back with no idle clock between them.

Top module: `memcyc_sequencer`

## Requirements
- R1: In the long mode (`fast_mode`=0) with no waits and `ready` high, the cycle has four states, so `ack` rises 4 clocks after the `addr_strobe` cycle.
- R2: In the short mode (`fast_mode`=1) with no waits and `ready` high, the cycle has two states, so `ack` rises 2 clocks after the `addr_strobe` cycle.
- R3: The wait count W is 0 when `mem_tacc` is at or below the processor allowance (15 in the long mode, 23 in the short mode). Otherwise W is ceil((`mem_tacc` − allowance)/10), capped at 15. Each wait adds one clock to the cycle.
- R4: After the W waits, each clock-edge sample of `ready` low at the decision point adds one more wait clock.
- R5: `addr_strobe` is high for exactly one clock, the T1 state, and `bus_addr` holds the request address from T1 to the end of the cycle.
- R6: `rd_strobe` (for reads) or `wr_strobe` (for writes) is high in every state from the one after T1 through the last completion state. The two strobes are never high together, and neither is high in T1.
- R7: A read captures `bus_din` on the last clock of the completion state and shows it on `rdata` with a one-clock `ack` pulse in the next clock. A write drives `req_wdata` on `bus_dout` for the whole cycle, pulses `ack` the same way and leaves `rdata` unchanged.
- R8: A request is taken only when the block is idle or in the last state of a cycle. A request pending in the last state starts the next T1 in the very next clock.
- R9: An active-low `rst_n` clears all strobes, `ack`, `rdata`, `bus_addr` and `bus_dout` at once, including in the middle of a cycle.
- R10: `fast_mode` and `mem_tacc` are sampled only when a request is taken. Changing them during a cycle does not change that cycle's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request pending |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| fast_mode | input | 1 | 1 = two-state cycle, 0 = four-state cycle |
| mem_tacc | input | TIME_W | Memory access time in tenths of a clock |
| ready | input | 1 | Memory ready; low stretches the cycle |
| bus_din | input | DATA_W | Read data from memory |
| addr_strobe | output | 1 | High in T1 |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| bus_addr | output | ADDR_W | Address to memory |
| bus_dout | output | DATA_W | Write data to memory |
| ack | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | DATA_W | Captured read data |

## Verification
Every result is timed from the clock in which `addr_strobe` is seen high, called index 0. The read or write strobe is due at indices 1 through N−1, and `ack` with `rdata` is due at index N. Here N is 4 or 2, plus the W waits from the access-time rule, plus the cycles the bench holds `ready` low. The bench samples at falling edges. It computes N from its own table of hand-worked wait counts, flags an `ack` that comes at any other index, and checks one index later that the pulse has dropped. In the back-to-back test, the second `addr_strobe` must appear at exactly the index where the first `ack` appears.

// File: rtl/memcyc_pkg.sv
`timescale 1ns/1ps
package memcyc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_TW,
    ST_T3,
    ST_T4
  } bus_state_e;

  // Whole clocks of waiting needed to cover the memory access time beyond
  // what the processor allows; rounded up, never negative, capped.
  function automatic int unsigned wait_clocks(input int unsigned mem_t,
                                              input int unsigned proc_t,
                                              input int unsigned unit,
                                              input int unsigned cap);
    int unsigned gap;
    int unsigned clocks;
    if (mem_t <= proc_t) begin
      clocks = 0;
    end else begin
      gap    = mem_t - proc_t;
      clocks = (gap + unit - 1) / unit;
      if (clocks > cap) clocks = cap;
    end
    return clocks;
  endfunction

endpackage

// File: rtl/memcyc_wait_calc.sv
`timescale 1ns/1ps
module memcyc_wait_calc #(
  parameter int unsigned TIME_W           = 8,
  parameter int unsigned WAIT_W           = 4,
  parameter int unsigned TICKS_PER_CLK    = 10,
  parameter int unsigned PROC_TACC_LEGACY = 15,
  parameter int unsigned PROC_TACC_FAST   = 23
) (
  input  logic              fast_mode,
  input  logic [TIME_W-1:0] mem_tacc,
  output logic [WAIT_W-1:0] wait_cnt
);
  import memcyc_pkg::*;

  localparam int unsigned WAIT_CAP = (1 << WAIT_W) - 1;

  int unsigned allowance;
  int unsigned clocks;

  always_comb begin
    allowance = fast_mode ? PROC_TACC_FAST : PROC_TACC_LEGACY;
    clocks    = wait_clocks(32'(mem_tacc), allowance, TICKS_PER_CLK, WAIT_CAP);
    wait_cnt  = WAIT_W'(clocks);
  end

endmodule

// File: rtl/memcyc_fsm.sv
`timescale 1ns/1ps
module memcyc_fsm #(
  parameter int unsigned WAIT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   ready,
  input  logic                   fast_mode,
  input  logic [WAIT_W-1:0]      wait_load,
  output memcyc_pkg::bus_state_e state,
  output logic                   take,
  output logic                   final_st,
  output logic                   cmpl_enter,
  output logic                   wait_zero
);
  import memcyc_pkg::*;

  bus_state_e        nxt;
  logic              fast_q;
  logic [WAIT_W-1:0] wcnt;
  logic              addr_ph;
  logic              decide;

  always_comb begin
    final_st   = (state == ST_T4) || (fast_q && state == ST_T2);
    addr_ph    = fast_q ? (state == ST_T1) : (state == ST_T2);
    decide     = addr_ph || (state == ST_TW);
    wait_zero  = (wcnt == '0);
    take       = req && ((state == ST_IDLE) || final_st);
    cmpl_enter = decide && wait_zero && ready;

    if (state == ST_IDLE || final_st) begin
      nxt = take ? ST_T1 : ST_IDLE;
    end else if (decide) begin
      if (cmpl_enter) nxt = fast_q ? ST_T2 : ST_T3;
      else            nxt = ST_TW;
    end else if (state == ST_T1) begin
      nxt = ST_T2;
    end else if (state == ST_T3) begin
      nxt = ST_T4;
    end else begin
      nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      fast_q <= 1'b0;
      wcnt   <= '0;
    end else begin
      state <= nxt;
      if (take) begin
        fast_q <= fast_mode;
        wcnt   <= wait_load;
      end else if (decide && !wait_zero) begin
        wcnt <= wcnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/memcyc_datapath.sv
`timescale 1ns/1ps
module memcyc_datapath #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              final_st,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              we_q,
  output logic [DATA_W-1:0] rdata,
  output logic              ack
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (take) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      we_q    <= req_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      ack   <= 1'b0;
    end else begin
      ack <= final_st;
      if (final_st && !we_q) rdata <= bus_din;
    end
  end

endmodule

// File: rtl/memcyc_sequencer.sv
`timescale 1ns/1ps
module memcyc_sequencer #(
  parameter int unsigned ADDR_W           = 16,
  parameter int unsigned DATA_W           = 16,
  parameter int unsigned TIME_W           = 8,
  parameter int unsigned WAIT_W           = 4,
  parameter int unsigned TICKS_PER_CLK    = 10,
  parameter int unsigned PROC_TACC_LEGACY = 15,
  parameter int unsigned PROC_TACC_FAST   = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              fast_mode,
  input  logic [TIME_W-1:0] mem_tacc,
  input  logic              ready,
  input  logic [DATA_W-1:0] bus_din,
  output logic              addr_strobe,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  import memcyc_pkg::*;

  // Named internal events, also observed by the bound checker.
  bus_state_e        state;
  logic              take;
  logic              final_st;
  logic              cmpl_enter;
  logic              wait_zero;
  logic              we_q;
  logic              data_phase;
  logic [WAIT_W-1:0] wait_load;

  memcyc_wait_calc #(
    .TIME_W          (TIME_W),
    .WAIT_W          (WAIT_W),
    .TICKS_PER_CLK   (TICKS_PER_CLK),
    .PROC_TACC_LEGACY(PROC_TACC_LEGACY),
    .PROC_TACC_FAST  (PROC_TACC_FAST)
  ) u_wait_calc (
    .fast_mode(fast_mode),
    .mem_tacc (mem_tacc),
    .wait_cnt (wait_load)
  );

  memcyc_fsm #(.WAIT_W(WAIT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .ready     (ready),
    .fast_mode (fast_mode),
    .wait_load (wait_load),
    .state     (state),
    .take      (take),
    .final_st  (final_st),
    .cmpl_enter(cmpl_enter),
    .wait_zero (wait_zero)
  );

  memcyc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .final_st (final_st),
    .req_we   (req_we),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .bus_din  (bus_din),
    .addr_q   (bus_addr),
    .wdata_q  (bus_dout),
    .we_q     (we_q),
    .rdata    (rdata),
    .ack      (ack)
  );

  always_comb begin
    data_phase  = (state != ST_IDLE) && (state != ST_T1);
    addr_strobe = (state == ST_T1);
    rd_strobe   = data_phase && !we_q;
    wr_strobe   = data_phase && we_q;
  end

endmodule

// File: rtl/memcyc_sequencer_chk.sv
`timescale 1ns/1ps
module memcyc_sequencer_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_strobe,
  input logic              rd_strobe,
  input logic              wr_strobe,
  input logic              ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              take,
  input logic              final_st,
  input logic              cmpl_enter,
  input logic              wait_zero,
  input logic              ready
);

  logic strobing;
  assign strobing = rd_strobe || wr_strobe;

  assert_as_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> !addr_strobe);

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobing |-> $stable(bus_addr));

  assert_no_strobe_in_t1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> !strobing);

  assert_rw_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));

  assert_waits_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobing && !wait_zero) |=> strobing);

  assert_not_ready_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobing && !ready && !final_st) |=> strobing);

  assert_ack_after_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(final_st));

  assert_take_starts_t1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> addr_strobe);

  assert_cmpl_not_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_enter |-> !final_st);

endmodule

bind memcyc_sequencer memcyc_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_strobe(addr_strobe),
  .rd_strobe  (rd_strobe),
  .wr_strobe  (wr_strobe),
  .ack        (ack),
  .bus_addr   (bus_addr),
  .take       (take),
  .final_st   (final_st),
  .cmpl_enter (cmpl_enter),
  .wait_zero  (wait_zero),
  .ready      (ready)
);

// File: tb/memcyc_sequencer_bench.sv
`timescale 1ns/1ps
module memcyc_sequencer_bench;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          fast_mode = 1'b0;
  logic [TW-1:0] mem_tacc = '0;
  logic          ready = 1'b1;
  logic [DW-1:0] bus_din = '0;
  logic          addr_strobe, rd_strobe, wr_strobe, ack;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  memcyc_sequencer u_memcyc_sequencer (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .fast_mode(fast_mode), .mem_tacc(mem_tacc),
    .ready(ready), .bus_din(bus_din), .addr_strobe(addr_strobe),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .ack(ack), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Stimulus table: mode, direction, memory time, ready-low clocks, and the
  // wait count worked out by hand from the access-time rule.
  localparam int NV = 12;
  localparam bit V_FAST  [NV] = '{0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 1, 0};
  localparam bit V_WE    [NV] = '{0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 1};
  localparam int V_MEM   [NV] = '{10, 10, 15, 16, 26, 23, 24, 34, 255, 10, 44, 35};
  localparam int V_LOW   [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 2, 1};
  localparam int V_WAITS [NV] = '{0, 0, 0, 1, 2, 0, 1, 2, 15, 0, 3, 2};
  // Rows: 0 R1, 1 R2, 2..8 R3 (8 = cap), 9..10 R4, 11 R7 write with waits.

  function automatic string tag_of(input int k);
    case (k)
      0:       return "R1";
      1:       return "R2";
      9, 10:   return "R4";
      11:      return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic run_txn(input bit fast, input bit we, input int mem, input int low,
                         input int waits, input logic [AW-1:0] addr,
                         input logic [DW-1:0] wd, input logic [DW-1:0] din,
                         input string tag);
    int base   = fast ? 2 : 4;
    int a      = fast ? 0 : 1;
    int total  = base + waits + low;
    int ack_at = -1;
    bit strobe_ok = 1'b1;
    bit dout_ok   = 1'b1;
    logic [DW-1:0] rd_before = rdata;
    @(negedge clk);
    fast_mode = fast; req_we = we; req_addr = addr; req_wdata = wd;
    mem_tacc = TW'(mem); bus_din = din; ready = 1'b0; req = 1'b1;
    @(negedge clk);  // index 0: T1
    chk(addr_strobe && !rd_strobe && !wr_strobe, "R5", "strobes in T1",
        {addr_strobe, rd_strobe, wr_strobe}, 3'b100);
    chk(bus_addr == addr, "R5", "bus_addr in T1", bus_addr, addr);
    req = 1'b0;
    // R10: mode and memory time change mid-cycle and must be ignored
    fast_mode = ~fast; mem_tacc = '1;
    ready = (0 >= a + waits + low);
    for (int i = 1; i < total; i++) begin
      @(negedge clk);
      if (ack && ack_at < 0) ack_at = i;
      if (addr_strobe || (we ? !(wr_strobe && !rd_strobe) : !(rd_strobe && !wr_strobe)))
        strobe_ok = 1'b0;
      if (we && bus_dout != wd) dout_ok = 1'b0;
      if (bus_addr != addr) strobe_ok = 1'b0;
      ready = (i >= a + waits + low);
    end
    @(negedge clk);  // index total
    if (ack && ack_at < 0) ack_at = total;
    chk(ack_at == total, tag, "ack index", ack_at, total);
    chk(strobe_ok && !rd_strobe && !wr_strobe, "R6", "strobe window",
        {strobe_ok, rd_strobe, wr_strobe}, 3'b100);
    if (!we) chk(rdata == din, "R7", "read data", rdata, din);
    else     chk(dout_ok && rdata == rd_before, "R7", "write data/rdata kept",
                 rdata, rd_before);
    @(negedge clk);
    chk(!ack, "R7", "ack single pulse", ack, 0);
    ready = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(!addr_strobe && !rd_strobe && !wr_strobe && !ack, "R9", "strobes in reset",
        {addr_strobe, rd_strobe, wr_strobe, ack}, 0);
    chk(rdata == 0 && bus_addr == 0 && bus_dout == 0, "R9", "data in reset",
        {rdata, bus_addr, bus_dout}, 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      run_txn(V_FAST[k], V_WE[k], V_MEM[k], V_LOW[k], V_WAITS[k],
              AW'(16'h1000 + k * 16'h0111), DW'(16'h5A00 + k),
              DW'(16'hA5A0 ^ k), tag_of(k));
    end

    // R10: legacy cycle, fast mode and long memory time applied after T1
    run_txn(1'b0, 1'b0, 5, 0, 0, 16'h0F0F, 16'h0, 16'h7777, "R10");

    // R8: back-to-back, request pending through T1 is not taken there
    @(negedge clk);
    fast_mode = 1'b1; mem_tacc = '0; ready = 1'b1; req_we = 1'b0;
    req_addr = 16'hAAAA; bus_din = 16'h1234; req = 1'b1;
    @(negedge clk);  // T1 of first
    chk(addr_strobe && bus_addr == 16'hAAAA, "R8", "first T1", bus_addr, 16'hAAAA);
    req_addr = 16'hBBBB;
    @(negedge clk);  // T2 of first
    chk(!addr_strobe && rd_strobe && bus_addr == 16'hAAAA, "R8", "not taken in T1",
        bus_addr, 16'hAAAA);
    @(negedge clk);  // T1 of second, ack of first
    chk(ack && rdata == 16'h1234, "R8", "first ack", rdata, 16'h1234);
    chk(addr_strobe && bus_addr == 16'hBBBB, "R8", "second T1 follows at once",
        bus_addr, 16'hBBBB);
    req = 1'b0; bus_din = 16'h5678;
    @(negedge clk);
    @(negedge clk);
    chk(ack && rdata == 16'h5678, "R8", "second ack", rdata, 16'h5678);
    @(negedge clk);

    // R9: reset in the middle of a write cycle
    fast_mode = 1'b0; mem_tacc = 8'd60; req_we = 1'b1; req_addr = 16'h4444;
    req_wdata = 16'h9999; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!wr_strobe && !addr_strobe && bus_addr == 0 && bus_dout == 0, "R9",
        "mid-cycle reset", {wr_strobe, bus_addr}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!ack && !wr_strobe, "R9", "no completion after reset", {ack, wr_strobe}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule